// File: doc/BRIEF.md
# Paged Open-Drain GPIO Controller

This block drives and senses 48 open-drain I/O lines through a byte-wide register bus with a 16-byte address window. Six port registers cover the lines. Line n sits in port n/8 at bit n%8. Writing 1 to a port bit makes the line sink current and pull low. Writing 0 releases the line, so an external pull-up holds it high and the line can serve as an input. Reading a port returns the complement of the synchronized line level.

A combined page/lock register does two jobs. It selects which bank of three registers appears at the paged offsets, and it carries one write lock per port. The banks hold edge polarity, edge enable and captured edge flags for the first 24 lines. Polarity and enable are brought out to a separate edge-detect block. That block returns one-cycle edge events, which set the flag bits. A summary register shows which flag bytes are non-zero. The synchronized line levels are also brought out so that the edge-detect block can use them.

Top module: `gpio_pg_top`

## Requirements
- R1: A write to offset k (0 to 5) with an unlocked port stores the byte. pinDriveLow[8k+b] equals bit b of that byte, and 1 means the line is pulled low.
- R2: Each line passes through two flops. pinSync shows a pinIn change after the second rising edge. A read of offset k (0 to 5) returns the bitwise complement of pinSync[8k+7:8k].
- R3: Offset 7 holds the page/lock register. Bits 7:6 select the page and bit k (0 to 5) locks port k. The register reads back the last value written to it.
- R4: While lock bit k is set, writes to offset k leave the port unchanged. Once the bit is cleared, writes to offset k take effect again.
- R5: Offsets 8, 9 and 10 reach byte j = offset-8 of a bank. Page 1 selects polarity, page 2 selects enable and page 3 selects the edge flags. polarityOut and enableOut bits [8j+7:8j] follow the stored bytes.
- R6: On page 0, writes to offsets 8 to 10 change nothing and reads of those offsets return 0x00. Reads of offsets 11 to 15 always return 0x00, and writes there change nothing.
- R7: A high edgeEvent bit sets its flag bit. The flag holds until a page-3 write replaces its byte. An event in the same cycle as such a write still sets its bit.
- R8: A read of offset 6 returns a summary byte. Bit j is 1 when flag byte j is non-zero, and bits 7:3 read 0. Writes to offset 6 change nothing.
- R9: Offsets 0 to 7 behave the same on every page.
- R10: After reset, all ports, the page/lock register, polarity, enable, flags and busRdData are zero, so every line is released.
- R11: busRdData is loaded on the rising edge where busRd is high and holds its value while busRd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register offset |
| busWr | input | 1 | Write strobe, sampled on the rising edge |
| busRd | input | 1 | Read strobe, sampled on the rising edge |
| busWrData | input | 8 | Write byte |
| busRdData | output | 8 | Registered read byte |
| pinIn | input | 48 | Sensed line levels |
| pinDriveLow | output | 48 | 1 makes the line sink current |
| pinSync | output | 48 | Synchronized line levels for the edge-detect block |
| polarityOut | output | 24 | Edge polarity per line |
| enableOut | output | 24 | Edge enable per line |
| edgeEvent | input | 24 | One-cycle edge pulses from the edge-detect block |

## Verification
The assertions check several properties on every cycle:
- at most one port write strobe is active;
- a locked port keeps its value;
- the page/lock register changes only when it is written;
- a captured edge flag is visible on the next cycle;
- unused offsets read zero;
- lines are released after reset.

Only the bench scenarios can show the rest:
- the inversion on read-back;
- the two-cycle synchronizer delay;
- the mapping of pages to banks;
- the summary byte;
- the race between a flag write and an edge event.

// File: rtl/gpio_pg_pkg.sv
package gpio_pg_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 4;
  localparam int NUM_PORTS  = 6;
  localparam int PAGED_CNT  = 3;
  localparam int LINE_CNT   = NUM_PORTS * BYTE_W;
  localparam int EDGE_LINES = PAGED_CNT * BYTE_W;
  localparam int PAGE_W     = 2;

  localparam logic [ADDR_W-1:0] OFS_PEND  = 4'h6;
  localparam logic [ADDR_W-1:0] OFS_PGLK  = 4'h7;
  localparam logic [ADDR_W-1:0] OFS_PAGED = 4'h8;

  typedef enum logic [PAGE_W-1:0] {
    PG_NONE = 2'd0,
    PG_POL  = 2'd1,
    PG_ENA  = 2'd2,
    PG_FLAG = 2'd3
  } page_e;

  typedef struct packed {
    logic [NUM_PORTS-1:0] portWe;
    logic [PAGED_CNT-1:0] polWe;
    logic [PAGED_CNT-1:0] enaWe;
    logic [PAGED_CNT-1:0] flagWe;
    logic [BYTE_W-1:0]    wrByte;
    logic                 rdStrobe;
    logic [ADDR_W-1:0]    rdAddr;
    logic [BYTE_W-1:0]    pageLock;
  } ctrl_strobe_t;
endpackage

// File: rtl/gpio_pg_ctrl.sv
module gpio_pg_ctrl
  import gpio_pg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BYTE_W-1:0] busWrData,
  output ctrl_strobe_t      strobes
);
  logic [BYTE_W-1:0] pageLockQ;
  page_e             curPage;
  logic [NUM_PORTS-1:0] lockBits;

  assign curPage  = page_e'(pageLockQ[BYTE_W-1 -: PAGE_W]);
  assign lockBits = pageLockQ[NUM_PORTS-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pageLockQ <= '0;
    else if (busWr && busAddr == OFS_PGLK) pageLockQ <= busWrData;
  end

  always_comb begin
    strobes          = '0;
    strobes.wrByte   = busWrData;
    strobes.rdStrobe = busRd;
    strobes.rdAddr   = busAddr;
    strobes.pageLock = pageLockQ;
    for (int k = 0; k < NUM_PORTS; k++) begin
      strobes.portWe[k] = busWr && (busAddr == ADDR_W'(k)) && !lockBits[k];
    end
    for (int j = 0; j < PAGED_CNT; j++) begin
      if (busWr && busAddr == OFS_PAGED + ADDR_W'(j)) begin
        strobes.polWe[j]  = (curPage == PG_POL);
        strobes.enaWe[j]  = (curPage == PG_ENA);
        strobes.flagWe[j] = (curPage == PG_FLAG);
      end
    end
  end

  // R4: at most one port can be written per cycle
  p_port_we_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.portWe));

  // R3: page/lock changes only by a write to its offset
  p_pglk_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busAddr == OFS_PGLK) |=> $stable(strobes.pageLock));

  // R6: no bank write strobe while page 0 is selected
  p_page0_nowrite_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pageLock[BYTE_W-1 -: PAGE_W] == 2'd0) |->
      ((strobes.polWe | strobes.enaWe | strobes.flagWe) == '0));
endmodule

// File: rtl/gpio_pg_datapath.sv
module gpio_pg_datapath
  import gpio_pg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_strobe_t          strobes,
  input  logic [LINE_CNT-1:0]   pinIn,
  input  logic [EDGE_LINES-1:0] edgeEvent,
  output logic [LINE_CNT-1:0]   pinDriveLow,
  output logic [LINE_CNT-1:0]   pinSync,
  output logic [EDGE_LINES-1:0] polarityOut,
  output logic [EDGE_LINES-1:0] enableOut,
  output logic [BYTE_W-1:0]     rdData
);
  logic [BYTE_W-1:0] portQ [NUM_PORTS];
  logic [BYTE_W-1:0] polQ  [PAGED_CNT];
  logic [BYTE_W-1:0] enaQ  [PAGED_CNT];
  logic [BYTE_W-1:0] flagQ [PAGED_CNT];
  logic [LINE_CNT-1:0] syncStage1;
  logic [BYTE_W-1:0] pendByte;
  logic [BYTE_W-1:0] rdNext;
  page_e             curPage;

  assign curPage = page_e'(strobes.pageLock[BYTE_W-1 -: PAGE_W]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncStage1 <= '0;
      pinSync    <= '0;
    end else begin
      syncStage1 <= pinIn;
      pinSync    <= syncStage1;
    end
  end

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PORTS; gp++) begin : g_port
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) portQ[gp] <= '0;
        else if (strobes.portWe[gp]) portQ[gp] <= strobes.wrByte;
      end
      assign pinDriveLow[gp*BYTE_W +: BYTE_W] = portQ[gp];

      // R4: a locked port holds its value across the edge
      p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
        strobes.pageLock[gp] |=> $stable(portQ[gp]));
    end

    for (gp = 0; gp < PAGED_CNT; gp++) begin : g_bank
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          polQ[gp]  <= '0;
          enaQ[gp]  <= '0;
          flagQ[gp] <= '0;
        end else begin
          if (strobes.polWe[gp]) polQ[gp] <= strobes.wrByte;
          if (strobes.enaWe[gp]) enaQ[gp] <= strobes.wrByte;
          flagQ[gp] <= (strobes.flagWe[gp] ? strobes.wrByte : flagQ[gp])
                       | edgeEvent[gp*BYTE_W +: BYTE_W];
        end
      end
      assign polarityOut[gp*BYTE_W +: BYTE_W] = polQ[gp];
      assign enableOut[gp*BYTE_W +: BYTE_W]   = enaQ[gp];
      assign pendByte[gp] = |flagQ[gp];

      // R7: an edge event is captured by the next cycle regardless of writes
      p_flag_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
        (edgeEvent[gp*BYTE_W +: BYTE_W] != '0) |=>
          ((flagQ[gp] & $past(edgeEvent[gp*BYTE_W +: BYTE_W]))
            == $past(edgeEvent[gp*BYTE_W +: BYTE_W])));
    end
  endgenerate

  assign pendByte[BYTE_W-1:PAGED_CNT] = '0;

  always_comb begin
    rdNext = '0;
    if (strobes.rdAddr < ADDR_W'(NUM_PORTS)) begin
      for (int k = 0; k < NUM_PORTS; k++)
        if (strobes.rdAddr == ADDR_W'(k)) rdNext = ~pinSync[k*BYTE_W +: BYTE_W];
    end else if (strobes.rdAddr == OFS_PEND) begin
      rdNext = pendByte;
    end else if (strobes.rdAddr == OFS_PGLK) begin
      rdNext = strobes.pageLock;
    end else begin
      for (int j = 0; j < PAGED_CNT; j++) begin
        if (strobes.rdAddr == OFS_PAGED + ADDR_W'(j)) begin
          unique case (curPage)
            PG_POL:  rdNext = polQ[j];
            PG_ENA:  rdNext = enaQ[j];
            PG_FLAG: rdNext = flagQ[j];
            default: rdNext = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strobes.rdStrobe) rdData <= rdNext;
  end

  // R6: reads above the paged slots return zero
  p_high_ofs_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdStrobe && strobes.rdAddr > OFS_PAGED + ADDR_W'(PAGED_CNT-1))
      |=> (rdData == '0));

  // R11: read data holds without a read strobe
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdStrobe |=> $stable(rdData));

  // R10: lines are released in the first cycle after reset
  p_reset_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pinDriveLow == '0));
endmodule

// File: rtl/gpio_pg_top.sv
module gpio_pg_top
  import gpio_pg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWr,
  input  logic                  busRd,
  input  logic [BYTE_W-1:0]     busWrData,
  output logic [BYTE_W-1:0]     busRdData,
  input  logic [LINE_CNT-1:0]   pinIn,
  output logic [LINE_CNT-1:0]   pinDriveLow,
  output logic [LINE_CNT-1:0]   pinSync,
  output logic [EDGE_LINES-1:0] polarityOut,
  output logic [EDGE_LINES-1:0] enableOut,
  input  logic [EDGE_LINES-1:0] edgeEvent
);
  ctrl_strobe_t strobes;

  gpio_pg_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWr     (busWr),
    .busRd     (busRd),
    .busWrData (busWrData),
    .strobes   (strobes)
  );

  gpio_pg_datapath dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .pinIn       (pinIn),
    .edgeEvent   (edgeEvent),
    .pinDriveLow (pinDriveLow),
    .pinSync     (pinSync),
    .polarityOut (polarityOut),
    .enableOut   (enableOut),
    .rdData      (busRdData)
  );
endmodule

// File: tb/gpio_pg_top_tb_top.sv
module gpio_pg_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [47:0] pinIn;
  logic [47:0] pinDriveLow;
  logic [47:0] pinSync;
  logic [23:0] polarityOut;
  logic [23:0] enableOut;
  logic [23:0] edgeEvent = '0;
  logic [47:0] extLow = '0;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 0;

  // model state
  logic [7:0] mPort [6];
  logic [7:0] mPol  [3];
  logic [7:0] mEna  [3];
  logic [7:0] mFlag [3];
  logic [7:0] mPgLk;

  always #2 clk = ~clk;

  // open-drain wire: low if the block sinks or an external source pulls low
  assign pinIn = ~(pinDriveLow | extLow);

  gpio_pg_top dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn),
    .pinDriveLow(pinDriveLow), .pinSync(pinSync), .polarityOut(polarityOut),
    .enableOut(enableOut), .edgeEvent(edgeEvent)
  );

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [3:0] a);
    logic [7:0] r;
    r = 8'h00;
    if (a < 4'd6) r = mPort[a] | extLow[a*8 +: 8];
    else if (a == 4'd6) r = {5'b0, |mFlag[2], |mFlag[1], |mFlag[0]};
    else if (a == 4'd7) r = mPgLk;
    else if (a <= 4'd10) begin
      case (mPgLk[7:6])
        2'd1: r = mPol[a-8];
        2'd2: r = mEna[a-8];
        2'd3: r = mFlag[a-8];
        default: r = 8'h00;
      endcase
    end
    return r;
  endfunction

  function automatic logic [47:0] expDrive();
    logic [47:0] v;
    for (int k = 0; k < 6; k++) v[k*8 +: 8] = mPort[k];
    return v;
  endfunction

  function automatic logic [23:0] expPol();
    logic [23:0] v;
    for (int j = 0; j < 3; j++) v[j*8 +: 8] = mPol[j];
    return v;
  endfunction

  function automatic logic [23:0] expEna();
    logic [23:0] v;
    for (int j = 0; j < 3; j++) v[j*8 +: 8] = mEna[j];
    return v;
  endfunction

  task automatic modelWrite(input logic [3:0] a, input logic [7:0] d);
    if (a < 4'd6) begin
      if (!mPgLk[a]) mPort[a] = d;
    end else if (a == 4'd7) mPgLk = d;
    else if (a >= 4'd8 && a <= 4'd10) begin
      case (mPgLk[7:6])
        2'd1: mPol[a-8] = d;
        2'd2: mEna[a-8] = d;
        2'd3: mFlag[a-8] = d;
        default: ;
      endcase
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    modelWrite(a, d);
    repeat (3) @(negedge clk);
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdData;
  endtask

  task automatic readCheck(input string req, input logic [3:0] a);
    logic [7:0] d;
    busRead(a, d);
    check(req, {40'b0, d}, {40'b0, expRead(a)});
  endtask

  initial begin
    logic [7:0] rd;
    for (int k = 0; k < 6; k++) mPort[k] = '0;
    for (int j = 0; j < 3; j++) begin mPol[j] = '0; mEna[j] = '0; mFlag[j] = '0; end
    mPgLk = '0;
    void'($urandom(32'h5eed_0017));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 rdData", {40'b0, busRdData}, 48'h0);
    check("R10 drive", pinDriveLow, 48'h0);
    check("R10 pol", {24'b0, polarityOut}, 48'h0);
    check("R10 ena", {24'b0, enableOut}, 48'h0);
    repeat (2) @(negedge clk);
    readCheck("R10 pglk", 4'd7);
    readCheck("R10 pend", 4'd6);

    // R1 port mapping: line 8k+b
    busWrite(4'd2, 8'h81);
    check("R1 drive map", pinDriveLow, 48'h0000_0081_0000);
    busWrite(4'd5, 8'h40);
    check("R1 drive map hi", pinDriveLow, 48'h4000_0081_0000);
    // R2 inverted read-back of driven lines
    readCheck("R2 driven readback", 4'd2);
    readCheck("R2 released readback", 4'd0);

    // R2 synchronizer latency
    @(negedge clk);
    extLow[3] = 1'b1;
    @(negedge clk);
    check("R2 sync 1 edge", {47'b0, pinSync[3]}, 48'h1);
    @(negedge clk);
    check("R2 sync 2 edges", {47'b0, pinSync[3]}, 48'h0);
    readCheck("R2 external low", 4'd0);
    extLow[3] = 1'b0;
    repeat (3) @(negedge clk);

    // R4 lock
    busWrite(4'd7, 8'b00_000100);
    busWrite(4'd2, 8'hFF);
    check("R4 locked port unchanged", {40'b0, pinDriveLow[23:16]}, 48'h81);
    busWrite(4'd7, 8'h00);
    busWrite(4'd2, 8'h3C);
    check("R4 unlocked port written", {40'b0, pinDriveLow[23:16]}, 48'h3C);

    // R5 banks
    busWrite(4'd7, 8'h40);
    busWrite(4'd9, 8'hA5);
    busWrite(4'd7, 8'h80);
    busWrite(4'd10, 8'h5A);
    check("R5 polarity out", {24'b0, polarityOut}, 48'h00A500);
    check("R5 enable out", {24'b0, enableOut}, 48'h5A0000);
    readCheck("R5 enable readback", 4'd10);
    readCheck("R9 port on page 2", 4'd2);
    readCheck("R3 pglk readback", 4'd7);

    // R6 page 0 and high offsets
    busWrite(4'd7, 8'h00);
    busWrite(4'd9, 8'hFF);
    check("R6 page0 write ignored", {24'b0, polarityOut}, 48'h00A500);
    readCheck("R6 page0 read zero", 4'd9);
    busWrite(4'd12, 8'hFF);
    readCheck("R6 high offset zero", 4'd12);
    busWrite(4'd6, 8'hFF);
    readCheck("R8 pend write ignored", 4'd6);

    // R7 / R8 flags
    @(negedge clk);
    edgeEvent = 24'h01_0010;
    @(negedge clk);
    edgeEvent = '0;
    mFlag[0] |= 8'h10; mFlag[2] |= 8'h01;
    readCheck("R8 pending summary", 4'd6);
    busWrite(4'd7, 8'hC0);
    readCheck("R7 flag byte0", 4'd8);
    readCheck("R7 flag byte2", 4'd10);
    // write and event in the same cycle
    @(negedge clk);
    busAddr = 4'd8; busWrData = 8'h00; busWr = 1'b1; edgeEvent = 24'h000002;
    @(negedge clk);
    busWr = 1'b0; edgeEvent = '0;
    mFlag[0] = 8'h02;
    readCheck("R7 event beats clear", 4'd8);
    busWrite(4'd10, 8'h00);
    readCheck("R7 flag cleared by write", 4'd10);
    readCheck("R9 pending on page 3", 4'd6);

    // R11 hold
    busRead(4'd7, rd);
    @(negedge clk);
    busAddr = 4'd0;
    repeat (2) @(negedge clk);
    check("R11 hold", {40'b0, busRdData}, {40'b0, rd});

    // constrained random mix
    for (int it = 0; it < 600; it++) begin
      logic [3:0] a;
      logic [7:0] d;
      int op;
      op = $urandom_range(0, 9);
      a  = 4'($urandom_range(0, 15));
      if (op < 2) a = 4'd7;
      d = 8'($urandom);
      if (op < 5) begin
        busWrite(a, d);
        check("R1 random drive", pinDriveLow, expDrive());
        check("R5 random pol", {24'b0, polarityOut}, {24'b0, expPol()});
        check("R5 random ena", {24'b0, enableOut}, {24'b0, expEna()});
      end else if (op == 9) begin
        @(negedge clk);
        edgeEvent = 24'($urandom) & 24'($urandom);
        @(negedge clk);
        for (int j = 0; j < 3; j++) mFlag[j] |= edgeEvent[j*8 +: 8];
        edgeEvent = '0;
      end else begin
        readCheck("R9 random read", a);
      end
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule